// File: doc/BRIEF.md
# CAN Low-Power Mode Sequencer

This block steers a CAN controller into and out of two low-power modes: a module-disable mode, requested by a control bit, and a system stop mode, requested globally. When a request arrives while frames are on the bus, the block does not cut the clocks at once. It first waits for a safe point on the bus, then for every internal engine to go quiet. Only then does it isolate the controller from the bus and report the new mode through its acknowledge and status outputs.

When the controller is already frozen, the bus is not in use, so the block takes a short path. Disable gates the protocol clocks in a single step. Stop raises the disable acknowledge and then the stop acknowledge. While the protocol clocks are off, an access-block output tells the register front end to refuse accesses to the timer, the error counters and the message buffers.

A request that rises while an entry sequence or a low-power mode is already in progress is remembered. It is served once the block is back in normal operation.

The states are RUN, WAIT_SAFE, DRAIN, GATE, DISABLED, STOP_FLAG and STOPPED. The transitions are:
- RUN to WAIT_SAFE on a request outside freeze.
- RUN to DISABLED on a disable request in freeze.
- RUN to STOP_FLAG on a stop request in freeze.
- WAIT_SAFE to DRAIN at a safe point.
- DRAIN to GATE (disable) or to STOP_FLAG (stop) once all engines are idle.
- GATE to DISABLED after one cycle.
- STOP_FLAG to STOPPED after one cycle.
- DISABLED to RUN when the disable request is cleared.
- STOPPED to RUN when the stop request is cleared.

Top module: `can_lpm_seq`

## Requirements
- R1: After reset the block is in RUN: both clock enables are 1, and not_rdy, dis_ack, lpm_ack, stop_ack, acc_block and rx_ignore are 0. can_tx_o follows can_tx_i, and rx_to_core_o follows can_rx_i.
- R2: Outside freeze, a request waits for a safe point. A safe point is one of: proto_idle_i=1; proto_busoff_i=1; or sample_stb_i=1 together with imsn_cnt_i=2 (third intermission bit, counted from 0) and can_rx_i=1 (recessive). Any other pattern keeps the block waiting, with the clocks on and the transmit output not forced.
- R3: After the safe point, the block stays in its drain phase while any bit of busy_i is 1. It leaves the drain phase on the first clock edge at which busy_i is all zero.
- R4: From the end of the drain phase (or from a freeze shortcut) until it returns to RUN, the block drives can_tx_o=1 and rx_to_core_o=1, and it asserts rx_ignore_o.
- R5: Disable entry: in the first cycle after the drain, both clock enables are 0, acc_block_o is 1, and not_rdy and dis_ack are still 0. In the next cycle not_rdy, dis_ack and lpm_ack are 1.
- R6: Stop entry: in the first cycle after the drain, not_rdy and dis_ack are 1 and stop_ack is 0. In the next cycle stop_ack and lpm_ack are 1.
- R7: A disable request in freeze mode gives, one cycle later, clocks off, together with dis_ack, not_rdy and lpm_ack all 1 and frz_ack 0. This holds whatever the state of the bus and the engines. Outside low power, frz_ack equals frz_mode_i.
- R8: A stop request in freeze mode gives, one cycle later, dis_ack=1, frz_ack=0 and stop_ack=0. One cycle after that, stop_ack=1.
- R9: In the cycle after dis_req_i is cleared in the disabled mode, the clocks are on and dis_ack, not_rdy, lpm_ack and acc_block are 0.
- R10: stop_ack stays 1 while stop_req_i is 1. In the cycle after stop_req_i is cleared, stop_ack and not_rdy are 0.
- R11: A request that rises while the block is not in RUN is remembered. It is served after the block returns to RUN, even if the request has been withdrawn in the meantime.
- R12: When both requests are taken in RUN in the same cycle, disable is served first. Stop follows after the disable request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dis_req_i | input | 1 | Module-disable request |
| stop_req_i | input | 1 | Global stop request |
| frz_mode_i | input | 1 | Controller is in freeze mode |
| proto_idle_i | input | 1 | Protocol engine is idle |
| proto_busoff_i | input | 1 | Protocol engine is bus-off |
| imsn_cnt_i | input | ICNT_W | Intermission bit counter |
| sample_stb_i | input | 1 | Bit sample point strobe |
| can_rx_i | input | 1 | Bus receive level (1 = recessive) |
| can_tx_i | input | 1 | Transmit level from the protocol engine |
| busy_i | input | NUM_ENG | Busy flags of the internal engines |
| rx_to_core_o | output | 1 | Receive level passed to the engine |
| can_tx_o | output | 1 | Transmit level to the bus |
| rx_ignore_o | output | 1 | Receive input is ignored |
| cpi_clk_en_o | output | 1 | Protocol engine clock enable |
| mbm_clk_en_o | output | 1 | Buffer manager clock enable |
| not_rdy_o | output | 1 | Not-ready status |
| dis_ack_o | output | 1 | Disable acknowledge |
| lpm_ack_o | output | 1 | Low-power acknowledge |
| frz_ack_o | output | 1 | Freeze acknowledge |
| stop_ack_o | output | 1 | Stop acknowledge |
| acc_block_o | output | 1 | Blocks access to timer, error counters and buffers |

## Verification
Disable and stop requests can both be taken in RUN in the same cycle. A stop request can also rise while a disable entry is still in flight. The bench provokes the first case by raising both requests on one edge, and the second by pulsing stop during the wait for a safe point. In both cases it checks that the stop acknowledge stays low through the whole disable episode. It then checks that the stop acknowledge rises exactly four cycles after the block returns to RUN. Random runs vary the safe-point kind, the wait length, the drain length and the hold time, and they check the cycle in which each output changes.

// File: rtl/can_lpm_pkg.sv
package can_lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT_SAFE,
        ST_DRAIN,
        ST_GATE,
        ST_DISABLED,
        ST_STOP_FLAG,
        ST_STOPPED
    } lpm_state_e;

    typedef enum logic {
        TGT_DIS,
        TGT_STOP
    } lpm_tgt_e;

endpackage

// File: rtl/can_lpm_safept.sv
module can_lpm_safept #(
    parameter int ICNT_W      = 2,
    parameter int INTERM_LAST = 2
) (
    input  logic              proto_idle_i,
    input  logic              proto_busoff_i,
    input  logic [ICNT_W-1:0] imsn_cnt_i,
    input  logic              sample_stb_i,
    input  logic              bus_rec_i,
    output logic              safe_o
);
    localparam logic [ICNT_W-1:0] LAST_CODE = ICNT_W'(INTERM_LAST);

    logic interm_ok;

    always_comb begin
        interm_ok = sample_stb_i && (imsn_cnt_i == LAST_CODE) && bus_rec_i;
        safe_o    = proto_idle_i || proto_busoff_i || interm_ok;
    end

    // R2: a bus-side safe point needs one of the three qualifying conditions
    always_comb begin
        if (safe_o && !proto_idle_i && !proto_busoff_i)
            a_r2_interm_recessive: assert (bus_rec_i && sample_stb_i);
    end
endmodule

// File: rtl/can_lpm_drain.sv
module can_lpm_drain #(
    parameter int NUM_ENG = 4
) (
    input  logic [NUM_ENG-1:0] busy_i,
    output logic               quiet_o
);
    logic [NUM_ENG:0] any_busy;

    assign any_busy[0] = 1'b0;

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        assign any_busy[g+1] = any_busy[g] | busy_i[g];
    end

    assign quiet_o = ~any_busy[NUM_ENG];
endmodule

// File: rtl/can_lpm_reqlatch.sv
module can_lpm_reqlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_req_i,
    input  logic stop_req_i,
    input  logic seq_busy_i,
    input  logic take_dis_i,
    input  logic take_stop_i,
    output logic dis_eff_o,
    output logic stop_eff_o
);
    logic dis_q, stop_q;
    logic pend_dis_q, pend_stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q       <= 1'b0;
            stop_q      <= 1'b0;
            pend_dis_q  <= 1'b0;
            pend_stop_q <= 1'b0;
        end else begin
            dis_q  <= dis_req_i;
            stop_q <= stop_req_i;
            if (take_dis_i)
                pend_dis_q <= 1'b0;
            else if (seq_busy_i && dis_req_i && !dis_q)
                pend_dis_q <= 1'b1;
            if (take_stop_i)
                pend_stop_q <= 1'b0;
            else if (seq_busy_i && stop_req_i && !stop_q)
                pend_stop_q <= 1'b1;
        end
    end

    assign dis_eff_o  = dis_req_i | pend_dis_q;
    assign stop_eff_o = stop_req_i | pend_stop_q;

    // R11: a stop request rising mid-sequence is remembered
    a_r11_stop_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy_i && stop_req_i && !stop_q) |=> stop_eff_o);

    // R11: a disable request rising mid-sequence is remembered
    a_r11_dis_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy_i && dis_req_i && !dis_q) |=> dis_eff_o);
endmodule

// File: rtl/can_lpm_fsm.sv
module can_lpm_fsm
    import can_lpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dis_eff_i,
    input  logic stop_eff_i,
    input  logic dis_req_i,
    input  logic stop_req_i,
    input  logic frz_i,
    input  logic safe_i,
    input  logic quiet_i,
    output logic take_dis_o,
    output logic take_stop_o,
    output logic seq_busy_o,
    output logic cpi_clk_en_o,
    output logic mbm_clk_en_o,
    output logic not_rdy_o,
    output logic dis_ack_o,
    output logic lpm_ack_o,
    output logic frz_ack_o,
    output logic stop_ack_o,
    output logic tx_force_o,
    output logic rx_ignore_o,
    output logic acc_block_o
);
    lpm_state_e state_q, state_d;
    lpm_tgt_e   tgt_q, tgt_d;

    // next state
    always_comb begin
        state_d     = state_q;
        tgt_d       = tgt_q;
        take_dis_o  = 1'b0;
        take_stop_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (dis_eff_i) begin
                    take_dis_o = 1'b1;
                    tgt_d      = TGT_DIS;
                    state_d    = frz_i ? ST_DISABLED : ST_WAIT_SAFE;
                end else if (stop_eff_i) begin
                    take_stop_o = 1'b1;
                    tgt_d       = TGT_STOP;
                    state_d     = frz_i ? ST_STOP_FLAG : ST_WAIT_SAFE;
                end
            end
            ST_WAIT_SAFE: if (safe_i) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (quiet_i)
                    state_d = (tgt_q == TGT_DIS) ? ST_GATE : ST_STOP_FLAG;
            end
            ST_GATE:      state_d = ST_DISABLED;
            ST_DISABLED:  if (!dis_req_i) state_d = ST_RUN;
            ST_STOP_FLAG: state_d = ST_STOPPED;
            ST_STOPPED:   if (!stop_req_i) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tgt_q   <= TGT_DIS;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        seq_busy_o   = (state_q != ST_RUN);
        cpi_clk_en_o = 1'b1;
        not_rdy_o    = 1'b0;
        dis_ack_o    = 1'b0;
        lpm_ack_o    = 1'b0;
        stop_ack_o   = 1'b0;
        tx_force_o   = 1'b0;
        acc_block_o  = 1'b0;
        unique case (state_q)
            ST_RUN, ST_WAIT_SAFE, ST_DRAIN: ;
            ST_GATE: begin
                cpi_clk_en_o = 1'b0;
                tx_force_o   = 1'b1;
                acc_block_o  = 1'b1;
            end
            ST_DISABLED: begin
                cpi_clk_en_o = 1'b0;
                not_rdy_o    = 1'b1;
                dis_ack_o    = 1'b1;
                lpm_ack_o    = 1'b1;
                tx_force_o   = 1'b1;
                acc_block_o  = 1'b1;
            end
            ST_STOP_FLAG: begin
                not_rdy_o  = 1'b1;
                dis_ack_o  = 1'b1;
                tx_force_o = 1'b1;
            end
            ST_STOPPED: begin
                not_rdy_o  = 1'b1;
                dis_ack_o  = 1'b1;
                lpm_ack_o  = 1'b1;
                stop_ack_o = 1'b1;
                tx_force_o = 1'b1;
            end
            default: ;
        endcase
        mbm_clk_en_o = cpi_clk_en_o;
        rx_ignore_o  = tx_force_o;
        frz_ack_o    = frz_i & ~dis_ack_o;
    end

    // R3: outside freeze, bus isolation starts only with all engines quiet
    a_r3_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_force_o) && !$past(frz_i)) |-> $past(quiet_i));

    // R5: on the normal disable path the clocks stop before the acknowledge
    a_r5_gate_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dis_ack_o) && !cpi_clk_en_o && !$past(frz_i)) |-> !$past(cpi_clk_en_o));

    // R6: stop acknowledge rises only after disable acknowledge is up
    a_r6_stop_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ack_o) |-> $past(dis_ack_o));

    // R9: clearing the disable request restores clocks and clears the acknowledge
    a_r9_dis_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_ack_o && !cpi_clk_en_o && !dis_req_i) |=> (cpi_clk_en_o && !dis_ack_o));

    // R10: stop acknowledge holds while the request stays
    a_r10_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ack_o && stop_req_i) |=> stop_ack_o);
endmodule

// File: rtl/can_lpm_seq.sv
module can_lpm_seq #(
    parameter int ICNT_W      = 2,
    parameter int INTERM_LAST = 2,
    parameter int NUM_ENG     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis_req_i,
    input  logic              stop_req_i,
    input  logic              frz_mode_i,
    input  logic              proto_idle_i,
    input  logic              proto_busoff_i,
    input  logic [ICNT_W-1:0] imsn_cnt_i,
    input  logic              sample_stb_i,
    input  logic              can_rx_i,
    input  logic              can_tx_i,
    input  logic [NUM_ENG-1:0] busy_i,
    output logic              rx_to_core_o,
    output logic              can_tx_o,
    output logic              rx_ignore_o,
    output logic              cpi_clk_en_o,
    output logic              mbm_clk_en_o,
    output logic              not_rdy_o,
    output logic              dis_ack_o,
    output logic              lpm_ack_o,
    output logic              frz_ack_o,
    output logic              stop_ack_o,
    output logic              acc_block_o
);
    logic safe, quiet;
    logic dis_eff, stop_eff;
    logic take_dis, take_stop, seq_busy;
    logic tx_force;

    can_lpm_safept #(
        .ICNT_W      (ICNT_W),
        .INTERM_LAST (INTERM_LAST)
    ) u_safept (
        .proto_idle_i   (proto_idle_i),
        .proto_busoff_i (proto_busoff_i),
        .imsn_cnt_i     (imsn_cnt_i),
        .sample_stb_i   (sample_stb_i),
        .bus_rec_i      (can_rx_i),
        .safe_o         (safe)
    );

    can_lpm_drain #(
        .NUM_ENG (NUM_ENG)
    ) u_drain (
        .busy_i  (busy_i),
        .quiet_o (quiet)
    );

    can_lpm_reqlatch u_reqlatch (
        .clk         (clk),
        .rst_n       (rst_n),
        .dis_req_i   (dis_req_i),
        .stop_req_i  (stop_req_i),
        .seq_busy_i  (seq_busy),
        .take_dis_i  (take_dis),
        .take_stop_i (take_stop),
        .dis_eff_o   (dis_eff),
        .stop_eff_o  (stop_eff)
    );

    can_lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dis_eff_i    (dis_eff),
        .stop_eff_i   (stop_eff),
        .dis_req_i    (dis_req_i),
        .stop_req_i   (stop_req_i),
        .frz_i        (frz_mode_i),
        .safe_i       (safe),
        .quiet_i      (quiet),
        .take_dis_o   (take_dis),
        .take_stop_o  (take_stop),
        .seq_busy_o   (seq_busy),
        .cpi_clk_en_o (cpi_clk_en_o),
        .mbm_clk_en_o (mbm_clk_en_o),
        .not_rdy_o    (not_rdy_o),
        .dis_ack_o    (dis_ack_o),
        .lpm_ack_o    (lpm_ack_o),
        .frz_ack_o    (frz_ack_o),
        .stop_ack_o   (stop_ack_o),
        .tx_force_o   (tx_force),
        .rx_ignore_o  (rx_ignore_o),
        .acc_block_o  (acc_block_o)
    );

    assign can_tx_o     = tx_force | can_tx_i;
    assign rx_to_core_o = rx_ignore_o | can_rx_i;

    // R4: while isolated, the bus sees recessive
    a_r4_tx_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ignore_o |-> (can_tx_o && rx_to_core_o));
endmodule

// File: tb/can_lpm_seq_tb.sv
module can_lpm_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis_req = 1'b0, stop_req = 1'b0, frz = 1'b0;
    logic       idle = 1'b0, busoff = 1'b0, stb = 1'b0;
    logic [1:0] cnt = 2'd0;
    logic       rx = 1'b1, tx_in = 1'b0;
    logic [3:0] busy = 4'd0;
    logic       rx_core, tx_o, rx_ign, cpi_en, mbm_en, not_rdy, dis_ack;
    logic       lpm_ack, frz_ack, stop_ack, acc_blk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int seed_init;

    always #10 clk = ~clk;

    can_lpm_seq u_dut (
        .clk (clk), .rst_n (rst_n), .dis_req_i (dis_req), .stop_req_i (stop_req),
        .frz_mode_i (frz), .proto_idle_i (idle), .proto_busoff_i (busoff),
        .imsn_cnt_i (cnt), .sample_stb_i (stb), .can_rx_i (rx), .can_tx_i (tx_in),
        .busy_i (busy), .rx_to_core_o (rx_core), .can_tx_o (tx_o),
        .rx_ignore_o (rx_ign), .cpi_clk_en_o (cpi_en), .mbm_clk_en_o (mbm_en),
        .not_rdy_o (not_rdy), .dis_ack_o (dis_ack), .lpm_ack_o (lpm_ack),
        .frz_ack_o (frz_ack), .stop_ack_o (stop_ack), .acc_block_o (acc_blk)
    );

    function automatic int exp_line(input logic forced, input logic lvl);
        return (forced || lvl) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            finish_run();
        end
    end

    task automatic run_seq(input int kind, input int safe_wait, input int safe_kind,
                           input int drain_len, input int hold);
        busy     = (drain_len > 0) ? (4'b0001 << ($urandom % 4)) : 4'd0;
        idle     = 1'b0;
        busoff   = 1'b0;
        stb      = 1'b0;
        rx       = 1'b1;
        dis_req  = (kind == 0);
        stop_req = (kind == 1);
        tick();
        for (int i = 0; i < safe_wait; i++) begin
            chk("R2", "tx not forced while waiting", tx_o, exp_line(1'b0, tx_in));
            chk("R2", "clock on while waiting", cpi_en, 1);
            stb = 1'b1;
            cnt = 2'($urandom % 2);
            tick();
            stb = 1'b0;
        end
        case (safe_kind)
            0:       idle = 1'b1;
            1:       busoff = 1'b1;
            default: begin stb = 1'b1; cnt = 2'd2; rx = 1'b1; end
        endcase
        tick();
        stb = 1'b0; cnt = 2'd0; idle = 1'b0; busoff = 1'b0;
        for (int i = 0; i < drain_len; i++) begin
            chk("R3", "not isolated while draining", tx_o, 0);
            chk("R3", "clock on while draining", cpi_en, 1);
            tick();
        end
        busy = 4'd0;
        rx   = 1'b0;
        tick();
        chk("R4", "tx forced recessive", tx_o, 1);
        chk("R4", "rx ignored", rx_core, 1);
        if (kind == 0) begin
            chk("R5", "cpi clock off", cpi_en, 0);
            chk("R5", "mbm clock off", mbm_en, 0);
            chk("R5", "access blocked", acc_blk, 1);
            chk("R5", "dis_ack not yet", dis_ack, 0);
            tick();
            chk("R5", "dis_ack set", dis_ack, 1);
            chk("R5", "not_rdy set", not_rdy, 1);
            chk("R5", "lpm_ack set", lpm_ack, 1);
            repeat (hold) tick();
            chk("R5", "dis_ack held", dis_ack, 1);
            dis_req = 1'b0; rx = 1'b1;
            tick();
            chk("R9", "clock back", cpi_en, 1);
            chk("R9", "dis_ack clear", dis_ack, 0);
            chk("R9", "not_rdy clear", not_rdy, 0);
            chk("R9", "access open", acc_blk, 0);
        end else begin
            chk("R6", "dis_ack set", dis_ack, 1);
            chk("R6", "not_rdy set", not_rdy, 1);
            chk("R6", "stop_ack not yet", stop_ack, 0);
            tick();
            chk("R6", "stop_ack set", stop_ack, 1);
            chk("R6", "lpm_ack set", lpm_ack, 1);
            repeat (hold) tick();
            chk("R10", "stop_ack held", stop_ack, 1);
            stop_req = 1'b0; rx = 1'b1;
            tick();
            chk("R10", "stop_ack clear", stop_ack, 0);
            chk("R10", "not_rdy clear", not_rdy, 0);
            chk("R10", "tx passthrough", tx_o, exp_line(1'b0, tx_in));
        end
        tick();
    endtask

    initial begin
        seed_init = $urandom(32'h5EED_1234);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", "cpi clock", cpi_en, 1);
        chk("R1", "mbm clock", mbm_en, 1);
        chk("R1", "not_rdy", not_rdy, 0);
        chk("R1", "dis_ack", dis_ack, 0);
        chk("R1", "lpm_ack", lpm_ack, 0);
        chk("R1", "stop_ack", stop_ack, 0);
        chk("R1", "acc_block", acc_blk, 0);
        chk("R1", "rx_ignore", rx_ign, 0);
        chk("R1", "tx passthrough", tx_o, exp_line(1'b0, tx_in));
        rx = 1'b0;
        #1;
        chk("R1", "rx passthrough", rx_core, 0);
        rx = 1'b1;

        // R2 directed: intermission corner cases
        dis_req = 1'b1;
        tick();
        cnt = 2'd2; rx = 1'b0; stb = 1'b1;
        tick();
        stb = 1'b0; rx = 1'b1;
        tick();
        chk("R2", "dominant third bit rejected", cpi_en, 1);
        cnt = 2'd2; stb = 1'b0;
        tick(); tick();
        chk("R2", "no strobe rejected", cpi_en, 1);
        stb = 1'b1;
        tick();
        stb = 1'b0; cnt = 2'd0;
        chk("R2", "in drain after accept", cpi_en, 1);
        tick();
        chk("R2", "recessive third bit accepted", cpi_en, 0);
        tick();
        dis_req = 1'b0;
        tick();
        chk("R9", "back to run", cpi_en, 1);

        // R7 / R8 freeze shortcut with busy engines and no safe point
        frz = 1'b1; busy = 4'hF;
        #1;
        chk("R7", "frz_ack follows freeze", frz_ack, 1);
        dis_req = 1'b1;
        tick();
        chk("R7", "clock off at once", cpi_en, 0);
        chk("R7", "dis_ack", dis_ack, 1);
        chk("R7", "not_rdy", not_rdy, 1);
        chk("R7", "lpm_ack", lpm_ack, 1);
        chk("R7", "frz_ack cleared", frz_ack, 0);
        chk("R4", "tx forced in freeze disable", tx_o, 1);
        dis_req = 1'b0;
        tick();
        chk("R9", "clock back after freeze disable", cpi_en, 1);
        chk("R7", "frz_ack restored", frz_ack, 1);
        stop_req = 1'b1;
        tick();
        chk("R8", "dis_ack", dis_ack, 1);
        chk("R8", "frz_ack cleared", frz_ack, 0);
        chk("R8", "stop_ack not yet", stop_ack, 0);
        tick();
        chk("R8", "stop_ack set", stop_ack, 1);
        stop_req = 1'b0;
        tick();
        chk("R10", "stop_ack clear after freeze stop", stop_ack, 0);
        frz = 1'b0; busy = 4'd0;
        tick();

        // R11 stop pulsed during a disable entry
        dis_req = 1'b1;
        tick();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        tick();
        idle = 1'b1;
        tick(); tick(); tick();
        chk("R11", "disabled reached", dis_ack, 1);
        chk("R11", "stop not served yet", stop_ack, 0);
        dis_req = 1'b0;
        tick();
        chk("R11", "run after disable", dis_ack, 0);
        tick(); tick(); tick();
        chk("R11", "stop flag stage", dis_ack, 1);
        chk("R11", "stop_ack low in flag stage", stop_ack, 0);
        tick();
        chk("R11", "latched stop served", stop_ack, 1);
        tick();
        chk("R11", "stop left", stop_ack, 0);

        // R12 simultaneous requests
        dis_req = 1'b1; stop_req = 1'b1;
        tick(); tick(); tick();
        chk("R12", "disable gate first", cpi_en, 0);
        chk("R12", "no stop_ack during disable", stop_ack, 0);
        tick();
        chk("R12", "disabled", dis_ack, 1);
        chk("R12", "stop_ack still low", stop_ack, 0);
        dis_req = 1'b0;
        tick();
        chk("R12", "run between", cpi_en, 1);
        tick(); tick(); tick(); tick();
        chk("R12", "stop follows", stop_ack, 1);
        stop_req = 1'b0;
        tick();
        chk("R12", "stop done", stop_ack, 0);
        idle = 1'b0;
        tick();

        // random sequences
        for (int k = 0; k < 24; k++) begin
            run_seq($urandom % 2, $urandom % 5, $urandom % 3, $urandom % 5, $urandom % 4);
        end

        finish_run();
    end
endmodule